// File: doc/BRIEF.md
# Variable-Length Instruction Framer

The framer takes a stream of instruction bytes, one byte per valid/ready handshake. It finds where each variable-length instruction begins and ends. An instruction is made of optional legacy and REX prefixes, one to three opcode bytes, an optional ModRM byte, an optional SIB byte, a displacement and an immediate.

For each instruction the framer records:
- the prefix flags and the segment override;
- the REX byte;
- the escape bytes and the final opcode byte;
- ModRM and SIB;
- the displacement and immediate lengths in bytes;
- the resolved operand, address and stack sizes.

The displacement and immediate bytes are counted off the stream but not assembled. A downstream stage that knows the lengths picks them up. The framer does not decode the meaning of the opcode. Per-opcode attributes come from an external combinational lookup port. The framer presents an opcode-map index and the current byte on that port. In the same cycle, the lookup answers whether the opcode takes a ModRM byte and which immediate size class it uses.

Back-pressure rules:
- A byte is taken on any rising edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high in every state except the error state.
- The output side has no back-pressure. `done` is a one-cycle pulse, and the captured fields are valid during that cycle.
- A byte that turns out not to be a prefix is handled as the first opcode byte in the same cycle, so the framer never stalls the stream.

Top module: `insn_framer`

## Requirements
- R1: After reset, `done` and `error` are 0 and `in_ready` is 1.
- R2: The legacy prefix encodings are 0x66 (operand-size override), 0x67 (address-size override), 0xF0 (lock), 0xF3 (rep) and 0xF2 (repne), and each sets its own flag. The segment prefixes 0x2E, 0x3E, 0x26, 0x64, 0x65 and 0x36 set `pfx_seg` to 1, 2, 3, 4, 5 and 6 respectively, and the last one seen wins.
- R3: A byte 0x40..0x4F is captured as the REX byte only when `long_mode` is 1. Otherwise it is an ordinary one-byte opcode and `rex_byte` stays 0.
- R4: A first opcode byte of 0x0F is an escape. A second opcode byte of 0x38 or 0x3A, following 0x0F, is a second escape. `opc_count` gives the number of opcode bytes, from 1 to 3. The lookup map index `lk_map` is 0, 1 or 2 for the first, second or third opcode byte.
- R5: Operand size depends on REX bit 3 (W) and the operand-size override. If W is set it is 8. Otherwise, if the override is present, it is 1<<`alt_op_log`. Otherwise it is 1<<`def_op_log`. Address size is 1<<`alt_addr_log` when the address-size override is present and 1<<`def_addr_log` otherwise. Stack size is 1<<`stack_log`.
- R6: The immediate size class codes are:
  - 0: no immediate;
  - 1: one byte;
  - 2: two bytes;
  - 3: the size, capped at 4;
  - 4: the full size.

  "Size" means the operand size, except for one-byte opcodes 0xA0..0xA3, which use the address size.
- R7: When `def_op_log` is 1 (16-bit rules), the displacement length depends on the ModRM mod field (bits 7:6) and rm field (bits 2:0). It is 2 bytes for mod=0 with rm=6, or for mod=2. It is 1 byte for mod=1, and 0 otherwise.
- R8: Otherwise (32/64-bit rules), the displacement is 4 bytes for mod=0 with rm=5, or for mod=2. It is 1 byte for mod=1, and 0 otherwise.
- R9: A SIB byte follows when rm=4 and mod≠3. If mod=0 and the SIB base field (bits 2:0) is 5, the displacement becomes 4 bytes.
- R10: Some one-byte opcodes take an extra immediate when the ModRM reg field (bits 5:3) has bits 5:4 = 00. For opcode 0xF6 the immediate is 1 byte. For opcode 0xF7 it equals the operand size, or 4 when the operand size is 8.
- R11: Fields arrive in this order: prefixes, opcode, ModRM, SIB, displacement, immediate, with absent fields skipped. `done` is high for exactly the one cycle after the handshake of the instruction's final byte.
- R12: The framer enters a sticky error state in two cases: a final opcode byte whose class code is 5..7, or more than `MAX_PREFIX` prefix bytes in one instruction. In that state `error` is 1 and `in_ready` is 0 until reset. Exactly `MAX_PREFIX` prefixes is accepted.
- R13: When `in_valid` is low, no byte is consumed, the state is held and `done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte available |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Framer can accept a byte |
| long_mode | input | 1 | 64-bit submode; REX recognised |
| def_op_log | input | 2 | log2 default operand size |
| alt_op_log | input | 2 | log2 operand size under override |
| def_addr_log | input | 2 | log2 default address size |
| alt_addr_log | input | 2 | log2 address size under override |
| stack_log | input | 2 | log2 stack width |
| lk_map | output | 2 | Opcode map index for lookup |
| lk_opcode | output | 8 | Byte presented to lookup |
| lk_modrm | input | 1 | Lookup: opcode takes ModRM |
| lk_imm_class | input | 3 | Lookup: immediate size class |
| done | output | 1 | One-cycle instruction-complete pulse |
| error | output | 1 | Sticky error flag |
| pfx_opsize | output | 1 | Operand-size override seen |
| pfx_addrsize | output | 1 | Address-size override seen |
| pfx_lock | output | 1 | Lock prefix seen |
| pfx_rep | output | 1 | Rep prefix seen |
| pfx_repne | output | 1 | Repne prefix seen |
| pfx_seg | output | 3 | Segment override code |
| rex_byte | output | 8 | Captured REX byte, 0 if none |
| opc_count | output | 2 | Number of opcode bytes |
| opc_esc1 | output | 8 | First escape byte |
| opc_esc2 | output | 8 | Second escape byte |
| opc_main | output | 8 | Final opcode byte |
| modrm_byte | output | 8 | ModRM byte |
| modrm_valid | output | 1 | ModRM present |
| sib_byte | output | 8 | SIB byte |
| sib_valid | output | 1 | SIB present |
| disp_bytes | output | 3 | Displacement length |
| imm_bytes | output | 4 | Immediate length |
| op_size | output | 4 | Operand size in bytes |
| addr_size | output | 4 | Address size in bytes |
| stack_size | output | 4 | Stack width in bytes |

## Verification
The assertions take two things for granted:
- The mode inputs stay unchanged from the first byte of an instruction to its last.
- The lookup port answers in the same cycle, with a value that depends only on `lk_map` and `lk_opcode`.

Given that, the assertions check:
- `done` never appears without an accepted byte;
- the error flag stays set once raised;
- SIB is never reported without a ModRM byte that calls for it.

The bench changes the mode inputs only while no instruction is in flight. It models the lookup as a pure combinational table. It also inserts idle gaps with `in_valid` low between and inside instructions, to exercise back-pressure.

// File: rtl/insn_framer_pkg.sv
package insn_framer_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LEN_W  = 4;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PREFIX, ST_OPCODE, ST_MODRM, ST_SIB, ST_DISP, ST_IMM, ST_ERROR
  } fsm_t;

  typedef enum logic [2:0] {
    PK_NONE, PK_OPSZ, PK_ADSZ, PK_SEG, PK_LOCK, PK_REP, PK_REPNE, PK_REX
  } pfx_kind_t;

  typedef struct packed {
    logic             opsz_ovr;
    logic             adsz_ovr;
    logic             lock;
    logic             rep;
    logic             repne;
    logic [2:0]       seg;
    byte_t            rex;
    logic [1:0]       opc_cnt;
    byte_t            esc1;
    byte_t            esc2;
    byte_t            opcode;
    byte_t            modrm;
    logic             modrm_v;
    byte_t            sib;
    logic             sib_v;
    logic [2:0]       disp_len;
    logic [LEN_W-1:0] imm_len;
    logic [LEN_W-1:0] op_size;
    logic [LEN_W-1:0] addr_size;
    logic [LEN_W-1:0] stack_size;
  } insn_fields_t;

  function automatic logic [LEN_W-1:0] log_to_bytes(input logic [1:0] lg);
    return LEN_W'(1) << lg;
  endfunction
endpackage

// File: rtl/insn_prefix_class.sv
module insn_prefix_class
  import insn_framer_pkg::*;
(
  input  byte_t      b,
  input  logic       long_mode,
  output pfx_kind_t  kind,
  output logic [2:0] seg
);
  always_comb begin
    kind = PK_NONE;
    seg  = 3'd0;
    case (b)
      8'h66: kind = PK_OPSZ;
      8'h67: kind = PK_ADSZ;
      8'hF0: kind = PK_LOCK;
      8'hF3: kind = PK_REP;
      8'hF2: kind = PK_REPNE;
      8'h2E: begin kind = PK_SEG; seg = 3'd1; end
      8'h3E: begin kind = PK_SEG; seg = 3'd2; end
      8'h26: begin kind = PK_SEG; seg = 3'd3; end
      8'h64: begin kind = PK_SEG; seg = 3'd4; end
      8'h65: begin kind = PK_SEG; seg = 3'd5; end
      8'h36: begin kind = PK_SEG; seg = 3'd6; end
      default: begin
        // REX class only counts as a prefix in the 64-bit submode (R3)
        if (b[7:4] == 4'h4 && long_mode) kind = PK_REX;
      end
    endcase
  end
endmodule

// File: rtl/insn_size_resolve.sv
module insn_size_resolve
  import insn_framer_pkg::*;
(
  input  logic             rex_w,
  input  logic             opsz_ovr,
  input  logic             adsz_ovr,
  input  logic [1:0]       def_op_log,
  input  logic [1:0]       alt_op_log,
  input  logic [1:0]       def_addr_log,
  input  logic [1:0]       alt_addr_log,
  input  logic [1:0]       stack_log,
  input  logic             one_byte,
  input  byte_t            opcode,
  input  logic [2:0]       imm_class,
  output logic [LEN_W-1:0] op_size,
  output logic [LEN_W-1:0] addr_size,
  output logic [LEN_W-1:0] stack_size,
  output logic [LEN_W-1:0] imm_len,
  output logic             class_bad
);
  logic [1:0]       op_log, addr_log, ref_log;
  logic [LEN_W-1:0] ref_size;
  logic             moffs;

  always_comb begin
    if (rex_w)         op_log = 2'd3;
    else if (opsz_ovr) op_log = alt_op_log;
    else               op_log = def_op_log;
    addr_log  = adsz_ovr ? alt_addr_log : def_addr_log;
    op_size    = log_to_bytes(op_log);
    addr_size  = log_to_bytes(addr_log);
    stack_size = log_to_bytes(stack_log);

    // one-byte 0xA0..0xA3 size their immediate by address width (R6)
    moffs    = one_byte && (opcode[7:2] == 6'b101000);
    ref_log  = moffs ? addr_log : op_log;
    ref_size = log_to_bytes(ref_log);

    class_bad = 1'b0;
    case (imm_class)
      3'd0: imm_len = '0;
      3'd1: imm_len = LEN_W'(1);
      3'd2: imm_len = LEN_W'(2);
      3'd3: imm_len = (ref_size > LEN_W'(4)) ? LEN_W'(4) : ref_size;
      3'd4: imm_len = ref_size;
      default: begin imm_len = '0; class_bad = 1'b1; end
    endcase
  end
endmodule

// File: rtl/insn_modrm_eval.sv
module insn_modrm_eval
  import insn_framer_pkg::*;
(
  input  byte_t            modrm,
  input  logic             addr16,
  input  logic             one_byte,
  input  byte_t            opcode,
  input  logic [LEN_W-1:0] op_size,
  input  logic [LEN_W-1:0] imm_in,
  output logic [2:0]       disp_len,
  output logic             need_sib,
  output logic [LEN_W-1:0] imm_out
);
  logic [1:0] md;
  logic [2:0] rg, rm;

  always_comb begin
    md = modrm[7:6];
    rg = modrm[5:3];
    rm = modrm[2:0];

    if (addr16) begin
      if ((md == 2'd0 && rm == 3'd6) || md == 2'd2) disp_len = 3'd2;
      else if (md == 2'd1)                          disp_len = 3'd1;
      else                                          disp_len = 3'd0;
    end else begin
      if ((md == 2'd0 && rm == 3'd5) || md == 2'd2) disp_len = 3'd4;
      else if (md == 2'd1)                          disp_len = 3'd1;
      else                                          disp_len = 3'd0;
    end

    need_sib = (rm == 3'd4) && (md != 2'd3);

    // group-3 test form carries an immediate the opcode class omits (R10)
    imm_out = imm_in;
    if (one_byte && rg[2:1] == 2'b00) begin
      if (opcode == 8'hF6)      imm_out = LEN_W'(1);
      else if (opcode == 8'hF7) imm_out = (op_size == LEN_W'(8)) ? LEN_W'(4) : op_size;
    end
  end
endmodule

// File: rtl/insn_framer.sv
module insn_framer
  import insn_framer_pkg::*;
#(
  parameter int unsigned MAX_PREFIX = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       in_ready,
  input  logic       long_mode,
  input  logic [1:0] def_op_log,
  input  logic [1:0] alt_op_log,
  input  logic [1:0] def_addr_log,
  input  logic [1:0] alt_addr_log,
  input  logic [1:0] stack_log,
  output logic [1:0] lk_map,
  output logic [7:0] lk_opcode,
  input  logic       lk_modrm,
  input  logic [2:0] lk_imm_class,
  output logic       done,
  output logic       error,
  output logic       pfx_opsize,
  output logic       pfx_addrsize,
  output logic       pfx_lock,
  output logic       pfx_rep,
  output logic       pfx_repne,
  output logic [2:0] pfx_seg,
  output logic [7:0] rex_byte,
  output logic [1:0] opc_count,
  output logic [7:0] opc_esc1,
  output logic [7:0] opc_esc2,
  output logic [7:0] opc_main,
  output logic [7:0] modrm_byte,
  output logic       modrm_valid,
  output logic [7:0] sib_byte,
  output logic       sib_valid,
  output logic [2:0] disp_bytes,
  output logic [3:0] imm_bytes,
  output logic [3:0] op_size,
  output logic [3:0] addr_size,
  output logic [3:0] stack_size
);
  localparam int unsigned PCNT_W = $clog2(MAX_PREFIX + 1);

  fsm_t             state_q, nxt_state;
  insn_fields_t     fld_q, nxt_fld, base;
  logic [LEN_W-1:0] cnt_q, nxt_cnt;
  logic [PCNT_W-1:0] pcnt_q, nxt_pcnt, pcnt_base;
  logic             done_q, err_q, fin;
  logic             accept, pfx_phase, is_prefix, opc_phase, esc_first, esc_second;

  pfx_kind_t        pk;
  logic [2:0]       pk_seg;
  logic [LEN_W-1:0] s_op, s_addr, s_stack, s_imm;
  logic             class_bad;
  logic [2:0]       m_disp;
  logic             m_sib;
  logic [LEN_W-1:0] m_imm;

  logic             do_route, r_sib;
  logic [2:0]       r_disp, sib_disp;
  logic [LEN_W-1:0] r_imm;

  assign in_ready  = (state_q != ST_ERROR);
  assign accept    = in_valid && in_ready;
  assign base      = (state_q == ST_IDLE) ? '0 : fld_q;
  assign pcnt_base = (state_q == ST_IDLE) ? '0 : pcnt_q;
  assign pfx_phase = (state_q == ST_IDLE) || (state_q == ST_PREFIX);
  assign is_prefix = pfx_phase && (pk != PK_NONE);
  assign opc_phase = (pfx_phase && !is_prefix) || (state_q == ST_OPCODE);
  assign esc_first  = (base.opc_cnt == 2'd0) && (in_byte == 8'h0F);
  assign esc_second = (base.opc_cnt == 2'd1) && (in_byte == 8'h38 || in_byte == 8'h3A);

  assign lk_map    = base.opc_cnt;
  assign lk_opcode = in_byte;

  insn_prefix_class u_pfx (
    .b(in_byte), .long_mode(long_mode), .kind(pk), .seg(pk_seg)
  );

  insn_size_resolve u_size (
    .rex_w(base.rex[3]), .opsz_ovr(base.opsz_ovr), .adsz_ovr(base.adsz_ovr),
    .def_op_log(def_op_log), .alt_op_log(alt_op_log),
    .def_addr_log(def_addr_log), .alt_addr_log(alt_addr_log),
    .stack_log(stack_log), .one_byte(base.opc_cnt == 2'd0), .opcode(in_byte),
    .imm_class(lk_imm_class), .op_size(s_op), .addr_size(s_addr),
    .stack_size(s_stack), .imm_len(s_imm), .class_bad(class_bad)
  );

  insn_modrm_eval u_modrm (
    .modrm(in_byte), .addr16(def_op_log == 2'd1), .one_byte(fld_q.opc_cnt == 2'd1),
    .opcode(fld_q.opcode), .op_size(fld_q.op_size), .imm_in(fld_q.imm_len),
    .disp_len(m_disp), .need_sib(m_sib), .imm_out(m_imm)
  );

  assign sib_disp = (fld_q.modrm[7:6] == 2'd0 && in_byte[2:0] == 3'd5) ? 3'd4 : fld_q.disp_len;

  always_comb begin
    nxt_state = state_q;
    nxt_fld   = fld_q;
    nxt_cnt   = cnt_q;
    nxt_pcnt  = pcnt_q;
    fin       = 1'b0;
    do_route  = 1'b0;
    r_sib     = 1'b0;
    r_disp    = 3'd0;
    r_imm     = '0;
    if (accept) begin
      nxt_fld  = base;
      nxt_pcnt = pcnt_base;
      if (is_prefix) begin
        if (pcnt_base == PCNT_W'(MAX_PREFIX)) begin
          nxt_state = ST_ERROR;
        end else begin
          nxt_pcnt  = pcnt_base + PCNT_W'(1);
          nxt_state = ST_PREFIX;
          case (pk)
            PK_OPSZ:  nxt_fld.opsz_ovr = 1'b1;
            PK_ADSZ:  nxt_fld.adsz_ovr = 1'b1;
            PK_LOCK:  nxt_fld.lock     = 1'b1;
            PK_REP:   nxt_fld.rep      = 1'b1;
            PK_REPNE: nxt_fld.repne    = 1'b1;
            PK_SEG:   nxt_fld.seg      = pk_seg;
            PK_REX:   nxt_fld.rex      = in_byte;
            default:  ;
          endcase
        end
      end else if (opc_phase) begin
        nxt_fld.opc_cnt = base.opc_cnt + 2'd1;
        if (esc_first) begin
          nxt_fld.esc1 = in_byte;
          nxt_state    = ST_OPCODE;
        end else if (esc_second) begin
          nxt_fld.esc2 = in_byte;
          nxt_state    = ST_OPCODE;
        end else if (class_bad) begin
          nxt_state = ST_ERROR;
        end else begin
          nxt_fld.opcode     = in_byte;
          nxt_fld.op_size    = s_op;
          nxt_fld.addr_size  = s_addr;
          nxt_fld.stack_size = s_stack;
          nxt_fld.imm_len    = s_imm;
          if (lk_modrm) begin
            nxt_state = ST_MODRM;
          end else begin
            do_route = 1'b1;
            r_imm    = s_imm;
          end
        end
      end else begin
        case (state_q)
          ST_MODRM: begin
            nxt_fld.modrm    = in_byte;
            nxt_fld.modrm_v  = 1'b1;
            nxt_fld.disp_len = m_disp;
            nxt_fld.imm_len  = m_imm;
            do_route = 1'b1;
            r_sib    = m_sib;
            r_disp   = m_disp;
            r_imm    = m_imm;
          end
          ST_SIB: begin
            nxt_fld.sib      = in_byte;
            nxt_fld.sib_v    = 1'b1;
            nxt_fld.disp_len = sib_disp;
            do_route = 1'b1;
            r_disp   = sib_disp;
            r_imm    = fld_q.imm_len;
          end
          ST_DISP: begin
            if (cnt_q == LEN_W'(1)) begin
              do_route = 1'b1;
              r_imm    = fld_q.imm_len;
            end else begin
              nxt_cnt = cnt_q - LEN_W'(1);
            end
          end
          ST_IMM: begin
            if (cnt_q == LEN_W'(1)) do_route = 1'b1;
            else                    nxt_cnt  = cnt_q - LEN_W'(1);
          end
          default: ;
        endcase
      end
      if (do_route) begin
        if (r_sib) begin
          nxt_state = ST_SIB;
        end else if (r_disp != 3'd0) begin
          nxt_state = ST_DISP;
          nxt_cnt   = LEN_W'(r_disp);
        end else if (r_imm != '0) begin
          nxt_state = ST_IMM;
          nxt_cnt   = r_imm;
        end else begin
          nxt_state = ST_IDLE;
          fin       = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fld_q   <= '0;
      cnt_q   <= '0;
      pcnt_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= fin;
      if (accept) begin
        state_q <= nxt_state;
        fld_q   <= nxt_fld;
        cnt_q   <= nxt_cnt;
        pcnt_q  <= nxt_pcnt;
        if (nxt_state == ST_ERROR) err_q <= 1'b1;
      end
    end
  end

  assign done         = done_q;
  assign error        = err_q;
  assign pfx_opsize   = fld_q.opsz_ovr;
  assign pfx_addrsize = fld_q.adsz_ovr;
  assign pfx_lock     = fld_q.lock;
  assign pfx_rep      = fld_q.rep;
  assign pfx_repne    = fld_q.repne;
  assign pfx_seg      = fld_q.seg;
  assign rex_byte     = fld_q.rex;
  assign opc_count    = fld_q.opc_cnt;
  assign opc_esc1     = fld_q.esc1;
  assign opc_esc2     = fld_q.esc2;
  assign opc_main     = fld_q.opcode;
  assign modrm_byte   = fld_q.modrm;
  assign modrm_valid  = fld_q.modrm_v;
  assign sib_byte     = fld_q.sib;
  assign sib_valid    = fld_q.sib_v;
  assign disp_bytes   = fld_q.disp_len;
  assign imm_bytes    = fld_q.imm_len;
  assign op_size      = fld_q.op_size;
  assign addr_size    = fld_q.addr_size;
  assign stack_size   = fld_q.stack_size;

  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  assert_err_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !in_ready);
  assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !err_q) |=> ($stable(state_q) && !done_q));
  assert_sib_modrm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && fld_q.sib_v) |-> (fld_q.modrm_v && fld_q.modrm[2:0] == 3'd4 && fld_q.modrm[7:6] != 2'd3));
  assert_opc_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (fld_q.opc_cnt != 2'd0));
  assert_rex_long_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && fld_q.rex != 8'h00) |-> (fld_q.rex[7:4] == 4'h4));
  assert_imm_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (fld_q.imm_len <= LEN_W'(8)));
endmodule

// File: tb/insn_framer_test.sv
module insn_framer_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic in_ready;
  logic long_mode = 1'b0;
  logic [1:0] def_op_log = 2'd2, alt_op_log = 2'd1, def_addr_log = 2'd2, alt_addr_log = 2'd1, stack_log = 2'd2;
  logic [1:0] lk_map;
  logic [7:0] lk_opcode;
  logic lk_modrm;
  logic [2:0] lk_imm_class;
  logic done, error, pfx_opsize, pfx_addrsize, pfx_lock, pfx_rep, pfx_repne;
  logic [2:0] pfx_seg;
  logic [7:0] rex_byte, opc_esc1, opc_esc2, opc_main, modrm_byte, sib_byte;
  logic [1:0] opc_count;
  logic modrm_valid, sib_valid;
  logic [2:0] disp_bytes;
  logic [3:0] imm_bytes, op_size, addr_size, stack_size;

  always #10 clk = ~clk;

  insn_framer uut (.*);

  // combinational opcode attribute table
  always_comb begin
    lk_modrm = 1'b0;
    lk_imm_class = 3'd0;
    case ({lk_map, lk_opcode})
      {2'd0, 8'h05}: lk_imm_class = 3'd3;
      {2'd0, 8'h89}, {2'd0, 8'h8B}, {2'd0, 8'hF6}, {2'd0, 8'hF7}: lk_modrm = 1'b1;
      {2'd0, 8'h81}: begin lk_modrm = 1'b1; lk_imm_class = 3'd3; end
      {2'd0, 8'h83}: begin lk_modrm = 1'b1; lk_imm_class = 3'd1; end
      {2'd0, 8'hA0}, {2'd0, 8'hA1}, {2'd0, 8'hA2}, {2'd0, 8'hA3}, {2'd0, 8'hB8}: lk_imm_class = 3'd4;
      {2'd0, 8'hC2}: lk_imm_class = 3'd2;
      {2'd0, 8'hD6}: lk_imm_class = 3'd7;
      {2'd1, 8'hAF}: lk_modrm = 1'b1;
      {2'd1, 8'h84}: lk_imm_class = 3'd3;
      {2'd2, 8'h00}: lk_modrm = 1'b1;
      {2'd2, 8'h0F}: begin lk_modrm = 1'b1; lk_imm_class = 3'd1; end
      default: ;
    endcase
  end

  typedef struct {
    logic [4:0] flags; // {opsize, addrsize, lock, rep, repne}
    logic [2:0] seg;
    logic [7:0] rex;
    logic [1:0] cnt;
    logic [7:0] e1, e2, opc, modrm;
    logic       mv;
    logic [7:0] sib;
    logic       sv;
    logic [2:0] disp;
    logic [3:0] imm, op, ad, st;
    string      tag;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int n_chk = 0, n_bad = 0, gcnt = 0;
  bit gaps = 1'b1;
  logic [3:0] d_op = 4'd4, d_ad = 4'd4, d_st = 4'd4;

  function automatic exp_t mk(input logic [7:0] opc, input string tag);
    exp_t x;
    x.flags = '0; x.seg = '0; x.rex = '0; x.cnt = 2'd1; x.e1 = '0; x.e2 = '0;
    x.opc = opc; x.modrm = '0; x.mv = 1'b0; x.sib = '0; x.sv = 1'b0;
    x.disp = '0; x.imm = '0; x.op = d_op; x.ad = d_ad; x.st = d_st; x.tag = tag;
    return x;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic push(input exp_t x);
    q.push_back(x);
  endtask

  task automatic db(input logic [7:0] b);
    @(negedge clk);
    if (gaps && (gcnt % 3) == 2) begin
      in_valid = 1'b0;
      @(negedge clk);
    end
    gcnt++;
    in_valid = 1'b1;
    in_byte  = b;
    @(posedge clk);
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) db(8'hA5);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) begin
        chk(1'b0, "R11 unexpected done", 64'd1, 64'd0);
      end else begin
        exp_t x;
        logic [63:0] a, b;
        x = q.pop_front();
        a = {pfx_opsize, pfx_addrsize, pfx_lock, pfx_rep, pfx_repne, pfx_seg, rex_byte, opc_count, opc_esc1, opc_esc2, opc_main};
        b = {x.flags, x.seg, x.rex, x.cnt, x.e1, x.e2, x.opc};
        chk(a === b, {x.tag, " prefix/opcode"}, a, b);
        a = {modrm_byte, modrm_valid, sib_byte, sib_valid, disp_bytes, imm_bytes, op_size, addr_size, stack_size};
        b = {x.modrm, x.mv, x.sib, x.sv, x.disp, x.imm, x.op, x.ad, x.st};
        chk(a === b, {x.tag, " modrm/lengths"}, a, b);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk(done == 1'b0 && error == 1'b0 && in_ready == 1'b1, "R1 reset state", {done, error, in_ready}, 3'b001);

    // R11 simple, R5 operand override, R2 prefix set
    push(mk(8'h90, "R11 one-byte")); db(8'h90);
    e = mk(8'h90, "R5 opsize override"); e.flags = 5'b10000; e.op = 4'd2; push(e); db(8'h66); db(8'h90);
    e = mk(8'h90, "R2 prefixes"); e.flags = 5'b01111; e.seg = 3'd4; e.ad = 4'd2; push(e);
    db(8'h2E); db(8'h64); db(8'hF0); db(8'hF3); db(8'hF2); db(8'h67); db(8'h90);

    // R6 immediate classes
    e = mk(8'h05, "R6 class3 imm4"); e.imm = 4'd4; push(e); db(8'h05); fill(4);
    e = mk(8'h05, "R6 class3 imm2"); e.flags = 5'b10000; e.op = 4'd2; e.imm = 4'd2; push(e); db(8'h66); db(8'h05); fill(2);
    e = mk(8'hC2, "R6 class2"); e.imm = 4'd2; push(e); db(8'hC2); fill(2);
    e = mk(8'hA0, "R6 moffs addr size"); e.flags = 5'b01000; e.ad = 4'd2; e.imm = 4'd2; push(e); db(8'h67); db(8'hA0); fill(2);
    e = mk(8'hB8, "R6 op size not addr"); e.flags = 5'b01000; e.ad = 4'd2; e.imm = 4'd4; push(e); db(8'h67); db(8'hB8); fill(4);

    // R8 displacement 32-bit rules
    e = mk(8'h89, "R8 mod1"); e.modrm = 8'h45; e.mv = 1; e.disp = 3'd1; push(e); db(8'h89); db(8'h45); fill(1);
    e = mk(8'h89, "R8 mod0 rm5"); e.modrm = 8'h05; e.mv = 1; e.disp = 3'd4; push(e); db(8'h89); db(8'h05); fill(4);
    e = mk(8'h89, "R8 mod2"); e.modrm = 8'h85; e.mv = 1; e.disp = 3'd4; push(e); db(8'h89); db(8'h85); fill(4);
    e = mk(8'h89, "R8 mod3"); e.modrm = 8'hC0; e.mv = 1; push(e); db(8'h89); db(8'hC0);

    // R9 SIB
    e = mk(8'h89, "R9 sib base5"); e.modrm = 8'h04; e.mv = 1; e.sib = 8'h25; e.sv = 1; e.disp = 3'd4; push(e);
    db(8'h89); db(8'h04); db(8'h25); fill(4);
    e = mk(8'h89, "R9 sib mod1"); e.modrm = 8'h44; e.mv = 1; e.sib = 8'h24; e.sv = 1; e.disp = 3'd1; push(e);
    db(8'h89); db(8'h44); db(8'h24); fill(1);
    e = mk(8'h89, "R9 sib no disp"); e.modrm = 8'h0C; e.mv = 1; e.sib = 8'h24; e.sv = 1; push(e);
    db(8'h89); db(8'h0C); db(8'h24);

    // R11 full ordering
    e = mk(8'h81, "R11 modrm+imm"); e.modrm = 8'hC0; e.mv = 1; e.imm = 4'd4; push(e); db(8'h81); db(8'hC0); fill(4);
    e = mk(8'h83, "R11 modrm sib disp imm"); e.modrm = 8'h84; e.mv = 1; e.sib = 8'h24; e.sv = 1; e.disp = 3'd4; e.imm = 4'd1; push(e);
    db(8'h83); db(8'h84); db(8'h24); fill(5);

    // R10 group-3 test form
    e = mk(8'hF6, "R10 F6 reg0"); e.modrm = 8'hC0; e.mv = 1; e.imm = 4'd1; push(e); db(8'hF6); db(8'hC0); fill(1);
    e = mk(8'hF6, "R10 F6 reg2"); e.modrm = 8'hD0; e.mv = 1; push(e); db(8'hF6); db(8'hD0);
    e = mk(8'hF6, "R10 F6 reg7"); e.modrm = 8'hF8; e.mv = 1; push(e); db(8'hF6); db(8'hF8);
    e = mk(8'hF7, "R10 F7 reg1"); e.modrm = 8'hC8; e.mv = 1; e.imm = 4'd4; push(e); db(8'hF7); db(8'hC8); fill(4);
    e = mk(8'hF7, "R10 F7 op2"); e.flags = 5'b10000; e.op = 4'd2; e.modrm = 8'hC0; e.mv = 1; e.imm = 4'd2; push(e);
    db(8'h66); db(8'hF7); db(8'hC0); fill(2);

    // R4 escapes
    e = mk(8'hAF, "R4 two-byte"); e.cnt = 2'd2; e.e1 = 8'h0F; e.modrm = 8'hC0; e.mv = 1; push(e); db(8'h0F); db(8'hAF); db(8'hC0);
    e = mk(8'h84, "R4 two-byte imm"); e.cnt = 2'd2; e.e1 = 8'h0F; e.imm = 4'd4; push(e); db(8'h0F); db(8'h84); fill(4);
    e = mk(8'h00, "R4 three-byte 38"); e.cnt = 2'd3; e.e1 = 8'h0F; e.e2 = 8'h38; e.modrm = 8'hC0; e.mv = 1; push(e);
    db(8'h0F); db(8'h38); db(8'h00); db(8'hC0);
    e = mk(8'h0F, "R4 three-byte 3A"); e.cnt = 2'd3; e.e1 = 8'h0F; e.e2 = 8'h3A; e.modrm = 8'hC0; e.mv = 1; e.imm = 4'd1; push(e);
    db(8'h0F); db(8'h3A); db(8'h0F); db(8'hC0); fill(1);

    // R3 REX byte outside long mode is an opcode
    push(mk(8'h48, "R3 rex as opcode")); db(8'h48);

    // R13 back-pressure hold mid-instruction
    e = mk(8'h05, "R13 hold"); e.imm = 4'd4; push(e); db(8'h05); fill(1);
    idle(6);
    chk(done == 1'b0 && in_ready == 1'b1, "R13 no progress while idle", {done, in_ready}, 2'b01);
    fill(3);

    // R5 stack width
    idle(1); stack_log = 2'd3; d_st = 4'd8;
    push(mk(8'h90, "R5 stack size")); db(8'h90);
    idle(2); stack_log = 2'd2; d_st = 4'd4;

    // R7 16-bit displacement rules
    idle(1); def_op_log = 2'd1; alt_op_log = 2'd2; def_addr_log = 2'd1; alt_addr_log = 2'd2; d_op = 4'd2; d_ad = 4'd2;
    e = mk(8'h89, "R7 mod0 rm6"); e.modrm = 8'h06; e.mv = 1; e.disp = 3'd2; push(e); db(8'h89); db(8'h06); fill(2);
    e = mk(8'h89, "R7 mod1"); e.modrm = 8'h46; e.mv = 1; e.disp = 3'd1; push(e); db(8'h89); db(8'h46); fill(1);
    e = mk(8'h89, "R7 mod2"); e.modrm = 8'h86; e.mv = 1; e.disp = 3'd2; push(e); db(8'h89); db(8'h86); fill(2);
    e = mk(8'h89, "R7 mod0 rm5"); e.modrm = 8'h05; e.mv = 1; push(e); db(8'h89); db(8'h05);
    e = mk(8'h90, "R5 16-bit override"); e.flags = 5'b10000; e.op = 4'd4; push(e); db(8'h66); db(8'h90);

    // long mode
    idle(2); long_mode = 1'b1; def_op_log = 2'd2; alt_op_log = 2'd1; def_addr_log = 2'd3; alt_addr_log = 2'd2; stack_log = 2'd3;
    d_op = 4'd4; d_ad = 4'd8; d_st = 4'd8;
    e = mk(8'h05, "R3 rex.w"); e.rex = 8'h48; e.op = 4'd8; e.imm = 4'd4; push(e); db(8'h48); db(8'h05); fill(4);
    e = mk(8'hB8, "R6 full imm8"); e.rex = 8'h48; e.op = 4'd8; e.imm = 4'd8; push(e); db(8'h48); db(8'hB8); fill(8);
    e = mk(8'h90, "R3 rex no W"); e.rex = 8'h41; push(e); db(8'h41); db(8'h90);
    e = mk(8'hA0, "R6 moffs long"); e.imm = 4'd8; push(e); db(8'hA0); fill(8);
    e = mk(8'hA0, "R6 moffs addr override"); e.flags = 5'b01000; e.ad = 4'd4; e.imm = 4'd4; push(e); db(8'h67); db(8'hA0); fill(4);
    e = mk(8'hF7, "R10 F7 op8 capped"); e.rex = 8'h48; e.op = 4'd8; e.modrm = 8'hC0; e.mv = 1; e.imm = 4'd4; push(e);
    db(8'h48); db(8'hF7); db(8'hC0); fill(4);

    // R12 prefix limit boundary: exactly 14 accepted
    idle(2); long_mode = 1'b0; def_addr_log = 2'd2; alt_addr_log = 2'd1; stack_log = 2'd2; d_ad = 4'd4; d_st = 4'd4;
    e = mk(8'h90, "R12 max prefixes ok"); e.flags = 5'b10000; e.op = 4'd2; push(e);
    for (int i = 0; i < 14; i++) db(8'h66);
    db(8'h90);
    idle(3);
    chk(q.size() == 0, "R11 all instructions framed", q.size(), 0);

    // R12 bad class
    db(8'hD6);
    @(negedge clk);
    in_valid = 1'b0;
    chk(error == 1'b1 && in_ready == 1'b0, "R12 bad class error", {error, in_ready}, 2'b10);
    in_valid = 1'b1; in_byte = 8'h90;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    chk(error == 1'b1 && in_ready == 1'b0, "R12 error sticky", {error, in_ready}, 2'b10);
    do_reset();
    @(negedge clk);
    chk(error == 1'b0 && in_ready == 1'b1, "R1 reset clears error", {error, in_ready}, 2'b01);

    // R12 prefix overflow
    gaps = 1'b0;
    for (int i = 0; i < 15; i++) db(8'h66);
    @(negedge clk);
    in_valid = 1'b0;
    chk(error == 1'b1 && in_ready == 1'b0, "R12 prefix overflow", {error, in_ready}, 2'b10);
    do_reset();
    idle(2);
    chk(q.size() == 0, "R11 no pending items", q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule